// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store command into the stream of byte addresses that the memory pipeline needs, one address per element. A command gives a base address, an element size (1, 2, 4 or 8 bytes), an addressing mode, a signed stride, a run-time vector length and an element mask. In unit-stride mode the elements are packed back to back. In constant-stride mode they are spaced by a multiple of the element size. In indexed (gather/scatter) mode each address is the base plus a signed byte offset taken from a separate index stream, which is fed from a vector register.

Each address leaves on a valid/ready handshake together with two flags. One marks the element as masked off, so that later stages cancel any exception it would raise. The other marks the final element. A one-cycle done pulse follows the final element. A vector length of zero produces no address, only the done pulse. A new command is accepted only while no command is in progress.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset `cmd_ready_o` is 1, `addr_valid_o` is 0 and `done_o` is 0.
- R2: Mode code 0 (unit stride): element i is at `base + i*2^size`, where `cmd_size_i` 0/1/2/3 means 1/2/4/8-byte elements, computed modulo 2^AW.
- R3: Mode code 1 (constant stride): element i is at `base + i*stride*2^size`, with the stride taken as two's complement and the result computed modulo 2^AW. A zero stride repeats the base address.
- R4: Mode codes 2 and 3 (indexed): element i is at `base + index_i`, where index_i is the i-th accepted value of the index stream, used as a signed byte offset and not scaled. Exactly one index is consumed for each address accepted.
- R5: `addr_masked_o` is the inverse of bit i of the command mask for element i (bit i belongs to element i, and 1 means active). Masked elements are still emitted.
- R6: A command emits exactly min(vl, MAX_VL) addresses, in element order, and `addr_last_o` is 1 on the final one only.
- R7: A command with vl = 0 emits no address, and `done_o` is 1 in the cycle after the command is accepted.
- R8: `done_o` is 1 for exactly one cycle, in the cycle after the final address is accepted. There is one pulse per command.
- R9: While `addr_valid_o` is 1 and `addr_ready_i` is 0 in a non-indexed mode, the address and its flags hold. No element is skipped or repeated under backpressure.
- R10: `cmd_ready_o` is 0 while a command is in progress. A command held on the inputs during that time waits and does not disturb the running one.
- R11: In modes 0 and 1, `idx_ready_o` stays 0, so the index stream is neither consumed nor used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Generator idle and able to take a command |
| cmd_mode_i | input | 2 | 0 unit stride, 1 constant stride, 2 or 3 indexed |
| cmd_size_i | input | 2 | Element size code: byte count is 2^code |
| cmd_base_i | input | AW | Base byte address |
| cmd_stride_i | input | AW | Signed stride in elements |
| cmd_vl_i | input | clog2(MAX_VL+1) | Vector length, clamped to MAX_VL |
| cmd_mask_i | input | MAX_VL | Element enables, bit i for element i |
| idx_valid_i | input | 1 | Index value present |
| idx_ready_o | output | 1 | Index consumed this cycle |
| idx_data_i | input | AW | Signed byte offset for indexed mode |
| addr_valid_o | output | 1 | Address present |
| addr_ready_i | input | 1 | Downstream takes the address |
| addr_o | output | AW | Element byte address |
| addr_masked_o | output | 1 | Element is masked off, so its exceptions are suppressed |
| addr_last_o | output | 1 | Final element of the command |
| done_o | output | 1 | One-cycle pulse when the command completes |

## Verification
The bench builds the block with AW = 32 and MAX_VL = 8. With a 4-bit length field, a vector length of 13 is legal on the port, so the clamp to MAX_VL can be exercised. A full-length command fits in a few cycles, so every mask bit position and the final-element flag are covered by short commands. The 32-bit width lets a base near the top of the address space show wraparound with 8-byte elements. A negative stride shows the two's complement handling. Commands are issued back to back while both handshakes are throttled, so the index stream runs ahead of the address stream and in some cycles falls behind it.

// File: rtl/vag_pkg.sv
`timescale 1ns/1ps
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_INDEX3 = 2'd3
  } vag_mode_e;

  function automatic logic mode_is_indexed(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/vag_seq.sv
`timescale 1ns/1ps
module vag_seq #(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int EW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           fire_i,
  output logic           busy_o,
  output logic [EW-1:0]  elem_o,
  output logic           last_o,
  output logic           done_o
);
  logic           busy_q, done_q;
  logic [VLW-1:0] cnt_q, vl_q, vl_eff;

  assign vl_eff = (vl_i > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_i;
  assign busy_o = busy_q;
  assign elem_o = cnt_q[EW-1:0];
  assign last_o = busy_q && (cnt_q == vl_q - VLW'(1));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      vl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        cnt_q <= '0;
        vl_q  <= vl_eff;
        if (vl_eff == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end else if (fire_i && busy_q) begin
        cnt_q <= cnt_q + VLW'(1);
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < vl_q) && (vl_q <= VLW'(MAX_VL)));
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/vag_addr.sv
`timescale 1ns/1ps
module vag_addr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] step_i,
  input  logic          indexed_i,
  input  logic          advance_i,
  input  logic [AW-1:0] idx_i,
  output logic          indexed_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, cur_q, step_q;
  logic          indexed_q;

  assign indexed_o = indexed_q;
  // indexed: offset is a byte offset, not scaled
  assign addr_o = indexed_q ? (base_q + idx_i) : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      cur_q     <= '0;
      step_q    <= '0;
      indexed_q <= 1'b0;
    end else if (load_i) begin
      base_q    <= base_i;
      cur_q     <= base_i;
      step_q    <= step_i;
      indexed_q <= indexed_i;
    end else if (advance_i) begin
      cur_q <= cur_q + step_q;
    end
  end

  // R2
  first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !indexed_i |=> addr_o == $past(base_i));
endmodule

// File: rtl/vec_addr_gen.sv
`timescale 1ns/1ps
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int EW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_mode_i,
  input  logic [1:0]        cmd_size_i,
  input  logic [AW-1:0]     cmd_base_i,
  input  logic [AW-1:0]     cmd_stride_i,
  input  logic [VLW-1:0]    cmd_vl_i,
  input  logic [MAX_VL-1:0] cmd_mask_i,
  input  logic              idx_valid_i,
  output logic              idx_ready_o,
  input  logic [AW-1:0]     idx_data_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_masked_o,
  output logic              addr_last_o,
  output logic              done_o
);
  logic              busy, last, idx_mode, cmd_fire, addr_fire;
  logic [EW-1:0]     elem;
  logic [AW-1:0]     step;
  logic [MAX_VL-1:0] mask_q;

  assign cmd_ready_o = !busy;
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;

  always_comb begin
    unique case (vag_mode_e'(cmd_mode_i))
      MODE_STRIDE: step = cmd_stride_i << cmd_size_i;
      default:     step = AW'(1) << cmd_size_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (cmd_fire) mask_q <= cmd_mask_i;
  end

  vag_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_fire),
    .vl_i    (cmd_vl_i),
    .fire_i  (addr_fire),
    .busy_o  (busy),
    .elem_o  (elem),
    .last_o  (last),
    .done_o  (done_o)
  );

  vag_addr #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cmd_fire),
    .base_i    (cmd_base_i),
    .step_i    (step),
    .indexed_i (mode_is_indexed(cmd_mode_i)),
    .advance_i (addr_fire),
    .idx_i     (idx_data_i),
    .indexed_o (idx_mode),
    .addr_o    (addr_o)
  );

  assign addr_valid_o  = busy && (!idx_mode || idx_valid_i);
  assign addr_fire     = addr_valid_o && addr_ready_i;
  assign idx_ready_o   = busy && idx_mode && addr_ready_i;
  assign addr_masked_o = !mask_q[elem];
  assign addr_last_o   = last;

  // R9
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i && !idx_mode |=>
      addr_valid_o && $stable(addr_o) && $stable(addr_masked_o) && $stable(addr_last_o));
  // R10
  no_cmd_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && addr_valid_o));
  // R4
  idx_with_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_i && idx_ready_o |-> addr_valid_o && addr_ready_i);
  // R6
  stop_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && addr_last_o |=> !addr_valid_o);
  // R11
  no_idx_in_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !idx_mode |-> !idx_ready_o);
endmodule

// File: tb/vec_addr_gen_bench.sv
`timescale 1ns/1ps
module vec_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int MAX_VL = 8;
  localparam int VLW = $clog2(MAX_VL + 1);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          masked;
    logic          last;
    logic          idx_mode;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_mode = '0, cmd_size = '0;
  logic [AW-1:0] cmd_base = '0, cmd_stride = '0;
  logic [VLW-1:0] cmd_vl = '0;
  logic [MAX_VL-1:0] cmd_mask = '0;
  logic idx_valid = 1'b0, idx_ready;
  logic [AW-1:0] idx_data = '0;
  logic addr_valid, addr_ready = 1'b0, addr_masked, addr_last, done;
  logic [AW-1:0] addr;

  exp_t exp_q[$];
  string tag_q[$];
  logic [AW-1:0] idx_q[$];

  int checks = 0, fails = 0, ncmds = 0, dones = 0, pat = 0;
  bit done_due = 0, hold_pend = 0, idx_fire_seen = 0, bp_on = 0, finished = 0;
  string done_tag = "R8";
  logic [AW-1:0] hold_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_addr_gen #(.AW(AW), .MAX_VL(MAX_VL)) u_vec_addr_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_mode_i(cmd_mode), .cmd_size_i(cmd_size),
    .cmd_base_i(cmd_base), .cmd_stride_i(cmd_stride),
    .cmd_vl_i(cmd_vl), .cmd_mask_i(cmd_mask),
    .idx_valid_i(idx_valid), .idx_ready_o(idx_ready), .idx_data_i(idx_data),
    .addr_valid_o(addr_valid), .addr_ready_i(addr_ready),
    .addr_o(addr), .addr_masked_o(addr_masked), .addr_last_o(addr_last),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // driver: computes expectations, then offers the command until taken
  task automatic send_cmd(input logic [1:0] mode, input logic [1:0] size,
                          input logic [AW-1:0] base, input logic [AW-1:0] stride,
                          input int vl, input logic [MAX_VL-1:0] mask, input int seed);
    int n;
    n = (vl > MAX_VL) ? MAX_VL : vl;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic [AW-1:0] off;
      string t;
      if (mode[1]) begin
        off = (i % 2 == 1) ? AW'(-(i * 24 + seed)) : AW'(i * 40 + seed * 1000);
        idx_q.push_back(off);
        e.addr = base + off;
        t = "R4";
      end else if (mode == 2'd1) begin
        off = stride * AW'(i);
        e.addr = base + (off << size);
        t = "R3";
      end else begin
        e.addr = base + (AW'(i) << size);
        t = "R2";
      end
      e.masked = !mask[i];
      e.last = (i == n - 1);
      e.idx_mode = mode[1];
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    @(posedge clk); #1;
    cmd_mode = mode; cmd_size = size; cmd_base = base; cmd_stride = stride;
    cmd_vl = VLW'(vl); cmd_mask = mask; cmd_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cmd_base = 32'hDEAD_BEEF; cmd_vl = VLW'(MAX_VL); cmd_mode = 2'd1;
    ncmds++;
    if (n == 0) begin
      done_due = 1;
      done_tag = "R7";
    end
  endtask

  // input shaping: backpressure pattern and index stream
  always @(posedge clk) begin
    #1;
    pat++;
    addr_ready = bp_on ? ((pat % 5 != 3) && (pat % 3 != 0)) : 1'b1;
    if (idx_fire_seen) void'(idx_q.pop_front());
    idx_fire_seen = 0;
    idx_valid = (idx_q.size() > 0) && (pat % 7 != 2);
    idx_data = (idx_q.size() > 0) ? idx_q[0] : '0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_due || done) begin
        chk(done == done_due, done_tag, "done pulse", 64'(done), 64'(done_due));
        done_due = 0;
        done_tag = "R8";
      end
      if (done) dones++;
      if (hold_pend) begin
        chk(addr_valid && addr == hold_addr, "R9", "held address",
            {31'd0, addr_valid, addr}, {32'd1, hold_addr});
        hold_pend = 0;
      end
      if (addr_valid) chk(!cmd_ready, "R10", "cmd_ready while busy", 64'(cmd_ready), 64'd0);
      if (addr_valid && addr_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected address", 64'(addr), 64'd0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(addr == e.addr, t, "address", 64'(addr), 64'(e.addr));
          chk(addr_masked == e.masked, "R5", "masked flag", 64'(addr_masked), 64'(e.masked));
          chk(addr_last == e.last, "R6", "last flag", 64'(addr_last), 64'(e.last));
          if (!e.idx_mode) chk(!idx_ready, "R11", "index ready in strided mode", 64'(idx_ready), 64'd0);
          if (e.last) done_due = 1;
        end
      end else if (addr_valid && !addr_ready && exp_q.size() > 0 && !exp_q[0].idx_mode) begin
        hold_pend = 1;
        hold_addr = addr;
      end
      idx_fire_seen = idx_valid && idx_ready;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 64'(cmd_ready), 64'd1);
    chk(addr_valid == 1'b0, "R1", "addr_valid after reset", 64'(addr_valid), 64'd0);
    chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);

    send_cmd(2'd0, 2'd2, 32'h0000_1000, '0, 5, 8'hFF, 0);
    send_cmd(2'd0, 2'd0, 32'h0000_2003, '0, 8, 8'hA5, 0);
    bp_on = 1;
    send_cmd(2'd0, 2'd3, 32'hFFFF_FFF0, '0, 4, 8'h0F, 0);
    send_cmd(2'd1, 2'd1, 32'h0000_4000, 32'd3, 6, 8'h3C, 0);
    send_cmd(2'd1, 2'd3, 32'h0000_8000, 32'hFFFF_FFFE, 8, 8'h0F, 0);
    send_cmd(2'd1, 2'd2, 32'h0000_9000, 32'd0, 3, 8'h02, 0);
    send_cmd(2'd2, 2'd2, 32'h0001_0000, '0, 7, 8'h5A, 1);
    send_cmd(2'd3, 2'd0, 32'h0002_0000, '0, 3, 8'hFF, 2);
    send_cmd(2'd0, 2'd1, 32'h0000_5000, '0, 0, 8'hFF, 0);
    bp_on = 0;
    send_cmd(2'd0, 2'd0, 32'h0000_6000, '0, 13, 8'h81, 0);
    send_cmd(2'd1, 2'd0, 32'h0000_7000, 32'd5, 1, 8'h00, 0);
    send_cmd(2'd2, 2'd3, 32'h0000_0100, '0, 2, 8'h03, 3);

    forever begin
      @(negedge clk);
      if (exp_q.size() == 0 && cmd_ready) break;
    end
    repeat (3) @(negedge clk);
    chk(dones == ncmds, "R8", "done pulse count", 64'(dones), 64'(ncmds));
    chk(idx_q.size() == 0, "R4", "indices left over", 64'(idx_q.size()), 64'd0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule